// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block collects 32 level-sensitive interrupt lines from peripherals and reduces them to one request toward a primary interrupt controller. Every clock the raw input levels are captured into a level register. A software-interrupt register is ORed into those levels, and the result is gated by an enable mask. The single combined request is the OR of the gated bits.

Beside the combined request, lines 21 to 30 can each be routed straight to a dedicated output. That output feeds the matching input of the primary controller. A passthrough-enable register selects these routes. A routed output follows its raw input with no clock delay. A routed output also appears as soon as its enable bit is set while the line is already high. Lines outside the 21..30 range can never be routed, and their passthrough outputs stay low.

Software reaches the block through a simple synchronous bus with a 4 KB window. The word index is taken from byte-address bits 11:2. A read returns its data on `bus_rdata` after the clock edge that samples the request. A write takes effect at the clock edge that samples it.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the level, enable, software-interrupt and passthrough-enable registers are zero, `irq_out` and every `pt_irq` bit are low, and `bus_rdata` is zero.
- R2: The level register takes the value of `irq_in` at every clock edge, and a read of word index 1 returns it. Software-interrupt bits are not included in this read.
- R3: `irq_out` is high exactly when ((level OR software) AND enable) is nonzero. It is evaluated from the registers without further delay.
- R4: A read of word index 0 returns (level OR software) AND enable.
- R5: A write to word index 2 sets every enable bit that is 1 in the data. A write to word index 3 clears every enable bit that is 1 in the data. Bits written as 0 keep their value in both cases.
- R6: A write to word index 4 sets, and a write to word index 5 clears, each software-interrupt bit that is 1 in the data. Software bits act like asserted inputs in R3 and R4.
- R7: A write to word index 8 sets passthrough-enable bits that are 1 in the data, restricted to bits 21..30 (mask 0x7FE00000). A read of word index 8 returns the passthrough-enable register. Byte-address bits 1:0 do not affect register selection.
- R8: A write to word index 9 clears every passthrough-enable bit that is 1 in the data.
- R9: For each line i in 21..30, `pt_irq[i]` equals `irq_in[i]` AND passthrough-enable bit i. It reacts to an input change with no clock edge, and it reacts in the cycle after a passthrough-enable write. `pt_irq` bits outside 21..30 are always low.
- R10: Reads of word indices 2, 3, 4, 5, 9 and every unmapped index (6, 7, 10 and above) return 0. Writes to indices 0, 1, 6, 7 and 10 and above change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Level-sensitive interrupt lines from peripherals |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid after the sampling edge |
| irq_out | output | 1 | Combined request toward the primary controller |
| pt_irq | output | 32 | Per-line passthrough outputs (only 21..30 can be active) |

## Verification
The level-capture assertion relies on `irq_in` being a known value on every edge after reset. It only compares cycles whose previous edge was outside reset. The bench holds all inputs at zero through reset and changes `irq_in` and the bus signals only on falling clock edges, so every rising edge sees settled values. The write-effect assertions assume `bus_wdata` stays stable for the cycle it is sampled. The bench keeps write data steady from one falling edge to the next.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Word indices decoded from byte-address bits [5:2]; upper index bits must be zero.
    typedef enum logic [3:0] {
        IDX_STATUS = 4'd0,
        IDX_RAW    = 4'd1,
        IDX_EN_SET = 4'd2,
        IDX_EN_CLR = 4'd3,
        IDX_SW_SET = 4'd4,
        IDX_SW_CLR = 4'd5,
        IDX_PT_SET = 4'd8,
        IDX_PT_CLR = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/sic_combine.sv
module sic_combine #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] lvl_q,
    input  logic [NLINES-1:0] soft_q,
    input  logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] status,
    output logic              irq_out
);

    logic [NLINES-1:0] eff_lvl;

    always_comb begin
        eff_lvl = lvl_q | soft_q;
        status  = eff_lvl & mask_q;
        irq_out = |status;
    end

    // R3: nothing enabled means no combined request
    a_r3_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out);

    // R6: an enabled software bit always raises the combined request
    a_r6_soft_raises_irq: assert property (@(posedge clk) disable iff (rst)
        ((soft_q & mask_q) != '0) |-> irq_out);

endmodule

// File: rtl/sic_bypass.sv
module sic_bypass #(
    parameter int                NLINES  = 32,
    parameter logic [NLINES-1:0] PT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] pt_en_q,
    output logic [NLINES-1:0] pt_irq
);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign pt_irq[i] = irq_in[i] & pt_en_q[i] & PT_MASK[i];
    end

    // R9: lines outside the routable range never drive their passthrough output
    a_r9_outside_range_low: assert property (@(posedge clk) disable iff (rst)
        (pt_irq & ~PT_MASK) == '0);

    // R9: a routed output is never high while its input is low
    a_r9_follows_input: assert property (@(posedge clk) disable iff (rst)
        (pt_irq & ~irq_in) == '0);

endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int                NLINES  = 32,
    parameter int                AW      = 12,
    parameter logic [NLINES-1:0] PT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    input  logic [NLINES-1:0] status,
    output logic [NLINES-1:0] lvl_q,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] soft_q,
    output logic [NLINES-1:0] pt_en_q,
    output logic [NLINES-1:0] bus_rdata
);

    localparam int WORD_W = AW - 2;

    logic [WORD_W-1:0] word;
    logic              hit;
    reg_idx_e          idx;
    logic              wr_any;
    logic              wr_mapped;
    logic [NLINES-1:0] rd_val;

    always_comb begin
        word      = bus_addr[AW-1:2];
        hit       = (word[WORD_W-1:4] == '0);
        idx       = reg_idx_e'(word[3:0]);
        wr_any    = bus_sel & bus_wr;
        wr_mapped = 1'b0;
        if (hit) begin
            unique case (idx)
                IDX_EN_SET, IDX_EN_CLR, IDX_SW_SET,
                IDX_SW_CLR, IDX_PT_SET, IDX_PT_CLR: wr_mapped = 1'b1;
                default:                            wr_mapped = 1'b0;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit) begin
            unique case (idx)
                IDX_STATUS: rd_val = status;
                IDX_RAW:    rd_val = lvl_q;
                IDX_PT_SET: rd_val = pt_en_q;
                default:    rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= '0;
            mask_q    <= '0;
            soft_q    <= '0;
            pt_en_q   <= '0;
            bus_rdata <= '0;
        end else begin
            lvl_q <= irq_in;
            if (bus_sel && !bus_wr) begin
                bus_rdata <= rd_val;
            end
            if (wr_any && hit) begin
                unique case (idx)
                    IDX_EN_SET: mask_q  <= mask_q | bus_wdata;
                    IDX_EN_CLR: mask_q  <= mask_q & ~bus_wdata;
                    IDX_SW_SET: soft_q  <= soft_q | bus_wdata;
                    IDX_SW_CLR: soft_q  <= soft_q & ~bus_wdata;
                    IDX_PT_SET: pt_en_q <= pt_en_q | (bus_wdata & PT_MASK);
                    IDX_PT_CLR: pt_en_q <= pt_en_q & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R2: level register holds the input seen at the previous edge
    a_r2_level_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lvl_q == $past(irq_in)));

    // R5: enable set and clear take effect after the write edge
    a_r5_enable_set: assert property (@(posedge clk) disable iff (rst)
        (wr_any && hit && idx == IDX_EN_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    a_r5_enable_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_any && hit && idx == IDX_EN_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));

    // R6: software clear removes the written bits
    a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_any && hit && idx == IDX_SW_CLR) |=> ((soft_q & $past(bus_wdata)) == '0));

    // R7: passthrough enables never leave the routable range
    a_r7_pt_range: assert property (@(posedge clk) disable iff (rst)
        (pt_en_q & ~PT_MASK) == '0);

    // R8: passthrough clear removes the written bits
    a_r8_pt_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_any && hit && idx == IDX_PT_CLR) |=> ((pt_en_q & $past(bus_wdata)) == '0));

    // R10: writes outside the writable indices leave all writable state alone
    a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_any && !wr_mapped) |=> ($stable(mask_q) && $stable(soft_q) && $stable(pt_en_q)));

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
    parameter int NLINES = 32,
    parameter int AW     = 12,
    parameter int PT_LO  = 21,
    parameter int PT_HI  = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    output logic              irq_out,
    output logic [NLINES-1:0] pt_irq
);

    function automatic logic [NLINES-1:0] range_mask();
        logic [NLINES-1:0] m;
        m = '0;
        for (int i = 0; i < NLINES; i++) begin
            m[i] = (i >= PT_LO) && (i <= PT_HI);
        end
        return m;
    endfunction

    localparam logic [NLINES-1:0] PT_MASK = range_mask();

    logic [NLINES-1:0] lvl_q;
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] soft_q;
    logic [NLINES-1:0] pt_en_q;
    logic [NLINES-1:0] status;

    sic_regs #(
        .NLINES  (NLINES),
        .AW      (AW),
        .PT_MASK (PT_MASK)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status),
        .lvl_q     (lvl_q),
        .mask_q    (mask_q),
        .soft_q    (soft_q),
        .pt_en_q   (pt_en_q),
        .bus_rdata (bus_rdata)
    );

    sic_combine #(
        .NLINES (NLINES)
    ) i_combine (
        .clk     (clk),
        .rst     (rst),
        .lvl_q   (lvl_q),
        .soft_q  (soft_q),
        .mask_q  (mask_q),
        .status  (status),
        .irq_out (irq_out)
    );

    sic_bypass #(
        .NLINES  (NLINES),
        .PT_MASK (PT_MASK)
    ) i_bypass (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .pt_en_q (pt_en_q),
        .pt_irq  (pt_irq)
    );

endmodule

// File: tb/test_sec_irq_ctrl.sv
module test_sec_irq_ctrl;

    localparam logic [31:0] PT_RANGE = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [31:0] pt_irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mask_m = '0;
    logic [31:0] soft_m = '0;
    logic [31:0] pt_m   = '0;

    always #4 clk = ~clk;

    sec_irq_ctrl i_sec_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .pt_irq    (pt_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = addr;
        @(negedge clk);
        data     = bus_rdata;
        bus_sel  = 1'b0;
    endtask

    task automatic set_input(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] lv);
        return (lv | soft_m) & mask_m;
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        check("R1 pt_irq", pt_irq, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        bus_read(12'h000, rd); check("R1 status", rd, 32'd0);
        bus_read(12'h004, rd); check("R1 raw", rd, 32'd0);
        bus_read(12'h020, rd); check("R1 pt_en", rd, 32'd0);

        // R2: walking one through the level register, R3 no request with mask zero
        for (int i = 0; i < 32; i++) begin
            set_input(32'h1 << i);
            bus_read(12'h004, rd);
            check("R2 raw level", rd, 32'h1 << i);
            check("R3 masked off", {31'd0, irq_out}, 32'd0);
        end

        // R3/R4/R5: sweep enable patterns against input patterns
        for (int k = 0; k < 32; k++) begin
            logic [31:0] m;
            logic [31:0] lv;
            m  = (32'h1 << k) | (32'h1 << ((k + 7) % 32));
            lv = (32'h1 << ((k * 5) % 32)) | (32'h1 << ((k + 7) % 32) & {32{k[0]}});
            bus_write(12'h008, m);
            mask_m = mask_m | m;
            set_input(lv);
            check("R3 irq_out", {31'd0, irq_out}, {31'd0, exp_status(lv) != 0});
            bus_read(12'h000, rd);
            check("R4 status", rd, exp_status(lv));
            bus_write(12'h00C, m);
            mask_m = mask_m & ~m;
            check("R5 clear", {31'd0, irq_out}, {31'd0, exp_status(lv) != 0});
        end

        // R5: set all, clear half, partial writes keep other bits
        set_input(32'hFFFF_FFFF);
        bus_write(12'h008, 32'hFFFF_FFFF); mask_m = 32'hFFFF_FFFF;
        bus_write(12'h00C, 32'h0000_FFFF); mask_m = 32'hFFFF_0000;
        bus_read(12'h000, rd); check("R5 partial clear", rd, 32'hFFFF_0000);
        bus_write(12'h008, 32'h0000_00F0); mask_m = 32'hFFFF_00F0;
        bus_read(12'h000, rd); check("R5 partial set", rd, 32'hFFFF_00F0);

        // R6: software interrupts
        set_input(32'h0);
        bus_write(12'h008, 32'hFFFF_FFFF); mask_m = 32'hFFFF_FFFF;
        check("R6 idle", {31'd0, irq_out}, 32'd0);
        bus_write(12'h010, 32'h0000_0F00); soft_m = 32'h0000_0F00;
        check("R6 soft irq", {31'd0, irq_out}, 32'd1);
        bus_read(12'h000, rd); check("R6 soft status", rd, 32'h0000_0F00);
        bus_read(12'h004, rd); check("R6 raw excludes soft", rd, 32'h0);
        bus_write(12'h014, 32'h0000_0300); soft_m = 32'h0000_0C00;
        bus_read(12'h000, rd); check("R6 soft partial clear", rd, 32'h0000_0C00);
        bus_write(12'h014, 32'hFFFF_FFFF); soft_m = 32'h0;
        check("R6 soft cleared", {31'd0, irq_out}, 32'd0);

        // R7/R9: passthrough enable set, restricted range
        bus_write(12'h020, 32'hFFFF_FFFF); pt_m = PT_RANGE;
        bus_read(12'h020, rd); check("R7 pt range", rd, PT_RANGE);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            irq_in = 32'h1 << i;
            #1;
            check("R9 immediate", pt_irq, (32'h1 << i) & pt_m);
        end

        // R8: clear some passthrough bits
        bus_write(12'h024, 32'h00F0_0000); pt_m = pt_m & ~32'h00F0_0000;
        bus_read(12'h020, rd); check("R8 pt clear", rd, 32'h7F00_0000);
        @(negedge clk); irq_in = 32'hFFFF_FFFF; #1;
        check("R9 after clear", pt_irq, 32'h7F00_0000);

        // R9: enabling a line that is already high refreshes its output
        bus_write(12'h024, 32'hFFFF_FFFF); pt_m = '0;
        check("R9 all off", pt_irq, 32'h0);
        bus_write(12'h020, 32'h0020_0000); pt_m = 32'h0020_0000;
        check("R9 refresh", pt_irq, 32'h0020_0000);

        // R7: low address bits do not change register selection
        bus_write(12'h023, 32'h4000_0000); pt_m = 32'h4020_0000;
        bus_read(12'h022, rd); check("R7 low addr bits", rd, 32'h4020_0000);

        // R10: write-only and unmapped reads return zero
        bus_write(12'h010, 32'h0000_0001); soft_m = 32'h1;
        bus_read(12'h008, rd); check("R10 read en_set", rd, 32'h0);
        bus_read(12'h00C, rd); check("R10 read en_clr", rd, 32'h0);
        bus_read(12'h010, rd); check("R10 read sw_set", rd, 32'h0);
        bus_read(12'h014, rd); check("R10 read sw_clr", rd, 32'h0);
        bus_read(12'h024, rd); check("R10 read pt_clr", rd, 32'h0);
        bus_read(12'h018, rd); check("R10 read idx6", rd, 32'h0);
        bus_read(12'h028, rd); check("R10 read idx10", rd, 32'h0);
        bus_read(12'hFFC, rd); check("R10 read top", rd, 32'h0);

        // R10: writes to read-only or unmapped indices change nothing
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h018, 32'hFFFF_FFFF);
        bus_write(12'h01C, 32'hFFFF_FFFF);
        bus_write(12'h028, 32'hFFFF_FFFF);
        bus_write(12'h060, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        set_input(32'h0);
        bus_read(12'h000, rd); check("R10 status kept", rd, exp_status(32'h0));
        bus_read(12'h020, rd); check("R10 pt kept", rd, pt_m);
        bus_write(12'h00C, 32'hFFFF_FFFE); mask_m = 32'h1;
        bus_read(12'h000, rd); check("R10 mask kept", rd, 32'h1);

        // R1: reset clears everything again
        @(negedge clk); rst = 1'b1; irq_in = 32'hFFFF_FFFF;
        @(negedge clk); @(negedge clk);
        check("R1 reset irq_out", {31'd0, irq_out}, 32'd0);
        check("R1 reset pt", pt_irq, 32'd0);
        irq_in = 32'h0;
        @(negedge clk); rst = 1'b0;
        mask_m = '0; soft_m = '0; pt_m = '0;
        bus_read(12'h000, rd); check("R1 reset status", rd, 32'h0);
        bus_read(12'h020, rd); check("R1 reset pt_en", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule